// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Read Target

This block is the target end of a four-bit, nibble-serial boot firmware bus. It serves one-byte memory reads. A host opens a cycle by pulling an active-low frame strobe low while it drives a start code. It then sends an ID-select nibble, a 28-bit address and a size nibble. Two turnaround clocks follow. The target then drives a ready sync, the data byte and its own turnaround. A whole read takes seventeen clocks. The bidirectional bus is split into an input nibble, an output nibble and an output enable. The pad ring joins these into one bus.

The byte comes from a synchronous memory port that is one byte wide. The block raises a single-clock request carrying address bits 19:0 as soon as the last address nibble has been taken in. The memory must return the byte on the next clock edge. The byte is then held until the data clocks.

The control is one state machine with these states:
- `ST_IDLE`
- `ST_IDSEL`
- `ST_ADDR`
- `ST_SIZE`
- `ST_HTAR0` and `ST_HTAR1` (the host turnaround)
- `ST_SYNC`
- `ST_DLO` and `ST_DHI`
- `ST_TTAR0` and `ST_TTAR1` (the target turnaround)
- `ST_SKIP`

Its transitions are:
- IDLE to IDSEL on a start.
- IDSEL stays in IDSEL on a repeated start.
- IDSEL goes back to IDLE on a non-start nibble while the strobe is low.
- IDSEL goes to ADDR on an ID match and to SKIP on a mismatch.
- ADDR stays in ADDR for seven nibbles, then goes to SIZE.
- SIZE goes to HTAR0 when the size is one byte and to SKIP otherwise.
- From HTAR0 the machine steps through HTAR1, SYNC, DLO, DHI, TTAR0 and TTAR1, then returns to IDLE.
- SKIP goes to IDLE once the strobe is high.

Top module: `nbus_read_target`

## Requirements
- R1: While either `rst_a_n` or `rst_b_n` is low, the block is held idle: `bus_oe`=0 and `mem_req`=0. Either reset has the same effect.
- R2: A cycle starts only on a rising edge where `frame_n`=0 and `bus_in`=4'b1101. The start code sent with `frame_n` high, or any other nibble sent with `frame_n` low, starts nothing.
- R3: If `frame_n` stays low across several start nibbles, the last one counts. The ID-select nibble is the first nibble sampled after `frame_n` rises.
- R4: The block answers only when the ID-select nibble equals `dev_id`. On a mismatch it never raises `mem_req` or `bus_oe` for that cycle, and it accepts the next start.
- R5: The seven nibbles after the ID nibble form a 28-bit address, most significant nibble first. `mem_req` is high for exactly one clock, the clock after the last address nibble is sampled. During that clock `mem_addr` equals address bits 19:0. The byte is taken from `mem_rdata` one edge later.
- R6: The size nibble must be 4'b0000. Any other value ends the cycle and the bus is never driven.
- R7: Clocks are counted so that clock 1 carries the start. The block does not drive the bus during the host turnaround, which is clocks 11 and 12. It drives 4'b0000 (ready) at clock 13 and 4'b1111 at clock 16, and it releases the bus at clock 17. `bus_oe` is high only during clocks 13 to 16.
- R8: Clock 14 carries the low nibble of the byte (bits 3:0) and clock 15 carries the high nibble (bits 7:4).
- R9: `standby` is high exactly when no cycle is in progress and `frame_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled on its rising edge |
| rst_a_n | input | 1 | First active-low reset |
| rst_b_n | input | 1 | Second active-low reset, with the same effect as the first |
| frame_n | input | 1 | Active-low frame strobe |
| bus_in | input | 4 | Nibble received from the bus |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| dev_id | input | 4 | Strapped device identity |
| mem_req | output | 1 | Single-clock read request to the memory |
| mem_addr | output | 20 | Byte address, valid while `mem_req` is high |
| mem_rdata | input | 8 | Byte returned one edge after the request |
| standby | output | 1 | High when idle with the strobe high |

## Verification
The bench sends bursts of one to three start nibbles. A design that latched the first start would read the repeated start code as the ID and drop the transfer. Mismatched IDs and non-zero sizes are mixed into random traffic. A target that let either one through would drive the bus over another device or the host. The bench checks the exact clocks on which the sync, the two data nibbles and the closing ones appear. A design that was off by one clock, or that swapped the nibble order, would return shifted or byte-swapped data. A start code with the strobe high, a second reset pulled in the middle of a transfer, and all-ones and all-zeros addresses cover spurious starts, a dead second reset and leakage of the upper address bits.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int unsigned NIB_W = 4;

    localparam logic [NIB_W-1:0] START_CODE = 4'b1101;
    localparam logic [NIB_W-1:0] ONE_BYTE   = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [NIB_W-1:0] TAR_ONES   = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IDSEL,
        ST_ADDR,
        ST_SIZE,
        ST_HTAR0,
        ST_HTAR1,
        ST_SYNC,
        ST_DLO,
        ST_DHI,
        ST_TTAR0,
        ST_TTAR1,
        ST_SKIP
    } state_t;

endpackage

// File: rtl/nbr_frame_fsm.sv
module nbr_frame_fsm
    import nbr_pkg::*;
#(
    parameter int unsigned ADDR_NIBBLES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] dev_id,
    output state_t           state,
    output logic             addr_shift
);

    localparam int unsigned CW = (ADDR_NIBBLES > 1) ? $clog2(ADDR_NIBBLES) : 1;
    localparam logic [CW-1:0] LAST_NIB = CW'(ADDR_NIBBLES - 1);

    state_t        state_q;
    state_t        state_d;
    logic [CW-1:0] nib_cnt_q;

    // State register and the address nibble counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            nib_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ADDR) begin
                nib_cnt_q <= nib_cnt_q + 1'b1;
            end else begin
                nib_cnt_q <= '0;
            end
        end
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!frame_n && bus_in == START_CODE) state_d = ST_IDSEL;
            end
            ST_IDSEL: begin
                if (!frame_n) begin
                    // A repeated start restarts the frame; other nibbles abandon it.
                    state_d = (bus_in == START_CODE) ? ST_IDSEL : ST_IDLE;
                end else begin
                    state_d = (bus_in == dev_id) ? ST_ADDR : ST_SKIP;
                end
            end
            ST_ADDR: begin
                if (nib_cnt_q == LAST_NIB) state_d = ST_SIZE;
            end
            ST_SIZE:  state_d = (bus_in == ONE_BYTE) ? ST_HTAR0 : ST_SKIP;
            ST_HTAR0: state_d = ST_HTAR1;
            ST_HTAR1: state_d = ST_SYNC;
            ST_SYNC:  state_d = ST_DLO;
            ST_DLO:   state_d = ST_DHI;
            ST_DHI:   state_d = ST_TTAR0;
            ST_TTAR0: state_d = ST_TTAR1;
            ST_TTAR1: state_d = ST_IDLE;
            ST_SKIP: begin
                if (frame_n) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    assign state      = state_q;
    assign addr_shift = (state_q == ST_ADDR);

endmodule

// File: rtl/nbr_addr_shift.sv
module nbr_addr_shift
    import nbr_pkg::*;
#(
    parameter int unsigned MEM_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [NIB_W-1:0]  nib,
    output logic [MEM_AW-1:0] addr
);

    // Only the low MEM_AW address bits are kept; older nibbles fall off the top.
    logic [MEM_AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (shift_en) begin
            addr_q <= {addr_q[MEM_AW-NIB_W-1:0], nib};
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/nbr_drive_mux.sv
module nbr_drive_mux
    import nbr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_t            state,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [NIB_W-1:0]  bus_out,
    output logic              bus_oe
);

    localparam int unsigned NIBS = DATA_W / NIB_W;

    logic [DATA_W-1:0] data_q;
    logic [NIB_W-1:0]  data_nib [NIBS];

    // Hold the byte that the memory returned during the size clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == ST_HTAR0) begin
            data_q <= mem_rdata;
        end
    end

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign data_nib[g] = data_q[g*NIB_W +: NIB_W];
    end

    // Output process: what the target places on the bus in each state.
    always_comb begin
        bus_out = TAR_ONES;
        bus_oe  = 1'b0;
        unique case (state)
            ST_SYNC: begin
                bus_out = SYNC_READY;
                bus_oe  = 1'b1;
            end
            ST_DLO: begin
                bus_out = data_nib[0];
                bus_oe  = 1'b1;
            end
            ST_DHI: begin
                bus_out = data_nib[NIBS-1];
                bus_oe  = 1'b1;
            end
            ST_TTAR0: begin
                bus_out = TAR_ONES;
                bus_oe  = 1'b1;
            end
            default: begin
                bus_out = TAR_ONES;
                bus_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nbus_read_target.sv
module nbus_read_target
    import nbr_pkg::*;
#(
    parameter int unsigned ADDR_NIBBLES = 7,
    parameter int unsigned MEM_AW       = 20,
    parameter int unsigned DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_a_n,
    input  logic              rst_b_n,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [3:0]        dev_id,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              standby
);

    logic   rst_n;
    state_t state;
    logic   addr_shift;

    // Either reset input resets the whole block.
    assign rst_n = rst_a_n & rst_b_n;

    nbr_frame_fsm #(
        .ADDR_NIBBLES(ADDR_NIBBLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .bus_in    (bus_in),
        .dev_id    (dev_id),
        .state     (state),
        .addr_shift(addr_shift)
    );

    nbr_addr_shift #(
        .MEM_AW(MEM_AW)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(addr_shift),
        .nib     (bus_in),
        .addr    (mem_addr)
    );

    nbr_drive_mux #(
        .DATA_W(DATA_W)
    ) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .mem_rdata(mem_rdata),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    // The request lasts for the size clock, so the byte is back before the sync.
    assign mem_req = (state == ST_SIZE);
    assign standby = (state == ST_IDLE) && frame_n;

endmodule

// File: rtl/nbus_read_target_chk.sv
module nbus_read_target_chk (
    input logic       clk,
    input logic       rst_a_n,
    input logic       rst_b_n,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic       mem_req,
    input logic       standby
);

    logic rst_n;
    assign rst_n = rst_a_n & rst_b_n;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!bus_oe && !mem_req));

    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r4_req_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !bus_oe);

    a_r7_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (bus_out == 4'b0000));

    a_r8_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |=> bus_oe);

    a_r7_release_after_four: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe, 3)) |=> !bus_oe);

    a_r9_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!bus_oe && !mem_req));

endmodule

bind nbus_read_target nbus_read_target_chk u_chk (
    .clk    (clk),
    .rst_a_n(rst_a_n),
    .rst_b_n(rst_b_n),
    .bus_out(bus_out),
    .bus_oe (bus_oe),
    .mem_req(mem_req),
    .standby(standby)
);

// File: tb/nbus_read_target_tb.sv
`timescale 1ns/1ps
module nbus_read_target_tb;

    logic        clk = 1'b0;
    logic        rst_a_n = 1'b0;
    logic        rst_b_n = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [3:0]  dev_id = 4'h3;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        standby;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nbus_read_target u_dut (
        .clk      (clk),
        .rst_a_n  (rst_a_n),
        .rst_b_n  (rst_b_n),
        .frame_n  (frame_n),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .dev_id   (dev_id),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .standby  (standby)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    // Synchronous memory model: one edge from request to data.
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem_byte(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Observe outputs (state after the previous edge), then drive the next field.
    task automatic cyc(input logic f, input logic [3:0] n,
                       output logic o_oe, output logic [3:0] o_out, output logic o_req,
                       output logic [19:0] o_addr, output logic o_sb);
        @(negedge clk);
        o_oe   = bus_oe;
        o_out  = bus_out;
        o_req  = mem_req;
        o_addr = mem_addr;
        o_sb   = standby;
        frame_n = f;
        bus_in  = n;
    endtask

    // One read frame; call j sets the field for clock j and observes after edge j-1.
    task automatic do_read(input logic [3:0] idsel, input logic [27:0] addr,
                           input logic [3:0] size, input int nstarts, input bit frame_hi_start);
        logic        ob_oe  [19];
        logic [3:0]  ob_out [19];
        logic        ob_req [19];
        logic [19:0] ob_addr[19];
        logic        ob_sb  [19];
        logic        f;
        logic [3:0]  n;
        bit hit;
        bit resp;
        int reqs;
        logic [7:0] expd;
        string tag;
        for (int s = 1; s < nstarts; s++) begin
            cyc(1'b0, 4'hD, ob_oe[0], ob_out[0], ob_req[0], ob_addr[0], ob_sb[0]);
        end
        for (int j = 1; j <= 18; j++) begin
            f = 1'b1;
            n = 4'hF;
            if (j == 1) begin
                f = frame_hi_start;
                n = 4'hD;
            end else if (j == 2) begin
                n = idsel;
            end else if (j <= 9) begin
                n = addr[4*(9-j) +: 4];
            end else if (j == 10) begin
                n = size;
            end
            cyc(f, n, ob_oe[j], ob_out[j], ob_req[j], ob_addr[j], ob_sb[j]);
        end
        hit  = !frame_hi_start && (idsel == dev_id);
        resp = hit && (size == 4'h0);
        expd = mem_byte(addr[19:0]);
        tag  = frame_hi_start ? "R2" : (!hit ? "R4" : (!resp ? "R6" : "R7"));
        reqs = 0;
        for (int j = 2; j <= 18; j++) if (ob_req[j]) reqs++;
        chk(reqs == (hit ? 1 : 0), hit ? "R5 request count" : {tag, " request count"}, reqs, hit ? 1 : 0);
        if (hit) begin
            chk(ob_req[10] === 1'b1, "R5 request clock", ob_req[10], 1);
            chk(ob_addr[10] == addr[19:0], "R5 address", ob_addr[10], addr[19:0]);
        end
        for (int j = 2; j <= 18; j++) begin
            bit exp_oe;
            exp_oe = resp && (j >= 13) && (j <= 16);
            chk(ob_oe[j] === exp_oe, {tag, " output enable"}, ob_oe[j], exp_oe);
        end
        if (resp) begin
            chk(ob_out[13] == 4'h0, "R7 ready sync", ob_out[13], 0);
            chk(ob_out[14] == expd[3:0], "R8 low nibble", ob_out[14], expd[3:0]);
            chk(ob_out[15] == expd[7:4], "R8 high nibble", ob_out[15], expd[7:4]);
            chk(ob_out[16] == 4'hF, "R7 closing ones", ob_out[16], 4'hF);
            chk(ob_sb[8] === 1'b0, "R9 busy not standby", ob_sb[8], 0);
        end
        chk(ob_sb[18] === 1'b1, "R9 standby after frame", ob_sb[18], 1);
    endtask

    initial begin
        logic        t_oe;
        logic [3:0]  t_out;
        logic        t_req;
        logic [19:0] t_addr;
        logic        t_sb;
        void'($urandom(32'd20240611));

        // R1: reset through the first input.
        repeat (3) @(negedge clk);
        chk(bus_oe === 1'b0 && mem_req === 1'b0, "R1 quiet in reset", {bus_oe, mem_req}, 0);
        rst_a_n = 1'b1;
        @(negedge clk);
        chk(standby === 1'b1, "R1 idle after reset", standby, 1);

        // R2/R5/R7/R8: plain read.
        do_read(4'h3, 28'h0012345, 4'h0, 1, 1'b0);
        // R3: repeated starts.
        do_read(4'h3, 28'hABCDE71, 4'h0, 3, 1'b0);
        // R4: foreign ID, then a good read.
        do_read(4'h9, 28'h0055555, 4'h0, 1, 1'b0);
        do_read(4'h3, 28'h0055555, 4'h0, 1, 1'b0);
        // R6: unsupported size.
        do_read(4'h3, 28'h00F00F0, 4'h1, 1, 1'b0);
        // R2: start code with the strobe high, after a frame-low non-start nibble.
        cyc(1'b0, 4'h5, t_oe, t_out, t_req, t_addr, t_sb);
        do_read(4'h3, 28'h0011111, 4'h0, 1, 1'b1);
        // R5: address extremes, upper bits must not leak.
        do_read(4'h3, 28'hFFFFFFF, 4'h0, 1, 1'b0);
        do_read(4'h3, 28'hFFF0000, 4'h0, 2, 1'b0);

        // R1: second reset in the middle of the sync clock.
        cyc(1'b0, 4'hD, t_oe, t_out, t_req, t_addr, t_sb);
        cyc(1'b1, 4'h3, t_oe, t_out, t_req, t_addr, t_sb);
        for (int k = 0; k < 7; k++) cyc(1'b1, 4'h2, t_oe, t_out, t_req, t_addr, t_sb);
        cyc(1'b1, 4'h0, t_oe, t_out, t_req, t_addr, t_sb);
        cyc(1'b1, 4'hF, t_oe, t_out, t_req, t_addr, t_sb);
        cyc(1'b1, 4'hF, t_oe, t_out, t_req, t_addr, t_sb);
        cyc(1'b1, 4'hF, t_oe, t_out, t_req, t_addr, t_sb);
        chk(t_oe === 1'b1, "R7 driving before second reset", t_oe, 1);
        rst_b_n = 1'b0;
        #1;
        chk(bus_oe === 1'b0 && mem_req === 1'b0, "R1 second reset quiets", {bus_oe, mem_req}, 0);
        repeat (2) @(negedge clk);
        rst_b_n = 1'b1;
        do_read(4'h3, 28'h0077777, 4'h0, 1, 1'b0);

        // Random traffic.
        for (int t = 0; t < 40; t++) begin
            logic [3:0]  rid;
            logic [3:0]  rsz;
            logic [27:0] ra;
            if (t % 10 == 0) begin
                @(negedge clk);
                dev_id = 4'($urandom());
            end
            rid = ($urandom() % 4 == 0) ? 4'($urandom()) : dev_id;
            rsz = ($urandom() % 6 == 0) ? 4'(1 + $urandom() % 15) : 4'h0;
            ra  = 28'($urandom());
            do_read(rid, ra, rsz, 1 + int'($urandom() % 3), 1'b0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule